// File: doc/BRIEF.md
# Multiprocessor 9-bit UART receiver

This block receives asynchronous serial frames for a slave node that shares one line with other nodes. The line is oversampled by a tick at sixteen times the bit rate. A start bit is confirmed at its middle sample. Each later bit is decided by a two-of-three vote around the middle of the bit. Two frame formats are supported. The 8-bit format carries eight data bits, and its stop bit is stored as the ninth status bit. The 9-bit format carries a ninth data bit that tells address frames from data frames.

A completed frame is loaded into the byte and ninth-bit outputs and sets a sticky interrupt flag, which software clears by writing one. An address-mode bit filters frames in 9-bit mode. While it is set, only address frames get through. When automatic matching is enabled, an address frame that carries the local node address clears the mode bit, so the data frames that follow reach the node. Nodes that were not addressed keep the bit set and do not see those frames.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, rx_irq_o, rx_data_o, rx_bit9_o and addr_mode_o are all 0.
- R2: In 8-bit mode (nine_bit_i=0), a frame is a 0 start bit, eight data bits sent least significant bit first, and a stop bit. The byte appears on rx_data_o and rx_irq_o becomes 1.
- R3: In 8-bit mode, the sampled stop bit value is stored in rx_bit9_o, whether it is 1 or 0.
- R4: In 9-bit mode (nine_bit_i=1), nine data bits follow the start bit. The ninth bit goes to rx_bit9_o: 1 marks an address frame and 0 marks a data frame.
- R5: A low level that is high again by the eighth tick after it was first seen (the middle sample of the start bit) is dropped, and no frame is received.
- R6: Each bit is the majority of its samples 7, 8 and 9, so a single wrong sample at sample 8 does not change the bit.
- R7: rx_irq_o stays 1 until a cycle with irq_clr_i=1. A frame that completes while rx_irq_o is 1 is discarded, and rx_data_o and rx_bit9_o keep their values.
- R8: In 9-bit mode with addr_mode_o=1, a frame whose ninth bit is 0 is discarded without loading and without setting rx_irq_o.
- R9: In 9-bit mode with addr_mode_o=1, every frame whose ninth bit is 1 is loaded and sets rx_irq_o, whether or not its byte matches node_addr_i.
- R10: With auto_match_en_i=1, a loaded address frame whose byte equals node_addr_i clears addr_mode_o in the same cycle that rx_irq_o is set.
- R11: With auto_match_en_i=0, or with a byte that differs from node_addr_i, addr_mode_o keeps its value, and hardware never sets it.
- R12: In 8-bit mode, addr_mode_o has no effect: every frame is loaded and sets rx_irq_o.
- R13: A cycle with addr_mode_we_i=1 loads addr_mode_wdata_i into addr_mode_o. A software write takes priority over an automatic clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversample strobe, OVS per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| nine_bit_i | input | 1 | 1 selects the 9-bit frame format |
| auto_match_en_i | input | 1 | Enables hardware address compare and mode clear |
| node_addr_i | input | DATA_W | Local node address |
| addr_mode_we_i | input | 1 | Software write strobe for the address-mode bit |
| addr_mode_wdata_i | input | 1 | Value written to the address-mode bit |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| rx_data_o | output | DATA_W | Received byte |
| rx_bit9_o | output | 1 | Ninth data bit, or the stop bit in 8-bit mode |
| rx_irq_o | output | 1 | Sticky receive interrupt flag |
| addr_mode_o | output | 1 | Address-mode enable bit |

## Verification
The bench uses the defaults DATA_W=8, OVS=16 and SYNC_STAGES=2, with one oversample tick every four clocks. At that rate the two-stage synchronizer settles well before the next tick, so line changes can be placed on exact sample positions. This makes it possible to flip sample 8 alone inside a data bit and to cut a start bit short before its middle sample. The 8-bit data width keeps the ninth-bit field clear of the byte, so matching and non-matching address frames and the following data frames can be checked on separate nodes set up one after another.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/mp_uart_rx_sync.sv
module mp_uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mp_uart_rx_deframer.sv
module mp_uart_rx_deframer
  import mp_uart_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              nine_bit_i,
  output logic              frame_vld_o,
  output logic [DATA_W-1:0] frame_data_o,
  output logic              frame_bit9_o,
  output logic              frame_nine_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(DATA_W + 2);
  localparam int unsigned MID   = OVS / 2;
  localparam logic [CNT_W-1:0] S_LO   = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] S_MID  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] S_HI   = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'(OVS - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W:0]   sh_q;
  logic              v_lo_q, v_mid_q, nine_q;
  logic [IDX_W-1:0]  last_idx;
  logic              vote;

  assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign vote     = maj3(v_lo_q, v_mid_q, line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      idx_q        <= '0;
      sh_q         <= '0;
      v_lo_q       <= 1'b1;
      v_mid_q      <= 1'b1;
      nine_q       <= 1'b0;
      frame_vld_o  <= 1'b0;
      frame_data_o <= '0;
      frame_bit9_o <= 1'b0;
      frame_nine_o <= 1'b0;
    end else begin
      frame_vld_o <= 1'b0;
      if (tick_i) begin
        if (state_q != ST_IDLE) begin
          cnt_q <= (cnt_q == S_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == S_LO)  v_lo_q  <= line_i;
          if (cnt_q == S_MID) v_mid_q <= line_i;
        end
        unique case (state_q)
          ST_IDLE: begin
            if (!line_i) begin
              state_q <= ST_START;
              cnt_q   <= CNT_W'(1);
              nine_q  <= nine_bit_i;
            end
          end
          ST_START: begin
            if (cnt_q == S_MID && line_i) begin
              state_q <= ST_IDLE;
            end else if (cnt_q == S_LAST) begin
              state_q <= ST_DATA;
              idx_q   <= '0;
            end
          end
          ST_DATA: begin
            if (cnt_q == S_HI) sh_q <= {vote, sh_q[DATA_W:1]};
            if (cnt_q == S_LAST) begin
              if (idx_q == last_idx) state_q <= ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == S_HI) begin
              frame_vld_o  <= 1'b1;
              frame_nine_o <= nine_q;
              state_q      <= ST_IDLE;
              if (nine_q) begin
                frame_data_o <= sh_q[DATA_W-1:0];
                frame_bit9_o <= sh_q[DATA_W];
              end else begin
                frame_data_o <= sh_q[DATA_W:1];
                frame_bit9_o <= vote;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_start_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == S_MID && line_i) |=> state_q == ST_IDLE);

  p_vld_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o);
endmodule

// File: rtl/mp_uart_rx_filter.sv
module mp_uart_rx_filter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              frame_bit9_i,
  input  logic              frame_nine_i,
  input  logic              auto_match_en_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic              addr_mode_we_i,
  input  logic              addr_mode_wdata_i,
  input  logic              irq_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              irq_o,
  output logic              addr_mode_o
);
  logic gated, accept, match_clr;

  // data frames are hidden while address mode is on (9-bit format only)
  assign gated     = frame_nine_i & addr_mode_o & ~frame_bit9_i;
  assign accept    = frame_vld_i & ~irq_o & ~gated;
  assign match_clr = accept & frame_nine_i & addr_mode_o & frame_bit9_i
                   & auto_match_en_i & (frame_data_i == node_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      bit9_o <= 1'b0;
      irq_o  <= 1'b0;
    end else if (accept) begin
      data_o <= frame_data_i;
      bit9_o <= frame_bit9_i;
      irq_o  <= 1'b1;
    end else if (irq_clr_i) begin
      irq_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             addr_mode_o <= 1'b0;
    else if (addr_mode_we_i) addr_mode_o <= addr_mode_wdata_i;
    else if (match_clr)      addr_mode_o <= 1'b0;
  end

  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  p_data_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> $stable(data_o) && $stable(bit9_o));

  p_drop_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && frame_nine_i && addr_mode_o && !frame_bit9_i && !irq_o)
      |=> !irq_o && $stable(data_o));

  p_clear_on_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && !irq_o && frame_nine_i && addr_mode_o && frame_bit9_i &&
     auto_match_en_i && frame_data_i == node_addr_i && !addr_mode_we_i)
      |=> !addr_mode_o && irq_o);

  p_no_hw_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_mode_o && !addr_mode_we_i) |=> !addr_mode_o);

  p_sw_write_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_mode_we_i |=> addr_mode_o == $past(addr_mode_wdata_i));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              nine_bit_i,
  input  logic              auto_match_en_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic              addr_mode_we_i,
  input  logic              addr_mode_wdata_i,
  input  logic              irq_clr_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_irq_o,
  output logic              addr_mode_o
);
  logic              line;
  logic              frame_vld, frame_bit9, frame_nine;
  logic [DATA_W-1:0] frame_data;

  mp_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line)
  );

  mp_uart_rx_deframer #(.DATA_W(DATA_W), .OVS(OVS)) u_deframer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .line_i      (line),
    .nine_bit_i  (nine_bit_i),
    .frame_vld_o (frame_vld),
    .frame_data_o(frame_data),
    .frame_bit9_o(frame_bit9),
    .frame_nine_o(frame_nine)
  );

  mp_uart_rx_filter #(.DATA_W(DATA_W)) u_filter (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .frame_vld_i      (frame_vld),
    .frame_data_i     (frame_data),
    .frame_bit9_i     (frame_bit9),
    .frame_nine_i     (frame_nine),
    .auto_match_en_i  (auto_match_en_i),
    .node_addr_i      (node_addr_i),
    .addr_mode_we_i   (addr_mode_we_i),
    .addr_mode_wdata_i(addr_mode_wdata_i),
    .irq_clr_i        (irq_clr_i),
    .data_o           (rx_data_o),
    .bit9_o           (rx_bit9_o),
    .irq_o            (rx_irq_o),
    .addr_mode_o      (addr_mode_o)
  );

  p_reset_clean_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> $past(frame_vld));
endmodule

// File: tb/mp_uart_rx_tb.sv
`timescale 1ns/1ps
module mp_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic       nine_bit_i = 1'b0;
  logic       auto_match_en_i = 1'b0;
  logic [7:0] node_addr_i = 8'h42;
  logic       addr_mode_we_i = 1'b0;
  logic       addr_mode_wdata_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_bit9_o, rx_irq_o, addr_mode_o;
  logic [1:0] tdiv = 2'd0;
  int         n_run = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick_i <= (tdiv == 2'd3);
  end

  mp_uart_rx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .nine_bit_i(nine_bit_i), .auto_match_en_i(auto_match_en_i),
    .node_addr_i(node_addr_i), .addr_mode_we_i(addr_mode_we_i),
    .addr_mode_wdata_i(addr_mode_wdata_i), .irq_clr_i(irq_clr_i),
    .rx_data_o(rx_data_o), .rx_bit9_o(rx_bit9_o), .rx_irq_o(rx_irq_o),
    .addr_mode_o(addr_mode_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one oversample slot: value held until the next tick samples it
  task automatic slot(input logic v);
    @(posedge clk);
    while (!tick_i) @(posedge clk);
    @(negedge clk);
    rxd_i = v;
  endtask

  task automatic send(input logic [8:0] bits, input int nbits, input logic stop, input int glitch);
    for (int k = 0; k < 16; k++) slot(1'b0);
    for (int b = 0; b < nbits; b++)
      for (int k = 0; k < 16; k++) slot((b == glitch && k == 8) ? ~bits[b] : bits[b]);
    for (int k = 0; k < 16; k++) slot(stop);
    for (int k = 0; k < 4; k++) slot(1'b1);
    repeat (6) @(negedge clk);
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr_i = 1'b1;
    @(negedge clk); irq_clr_i = 1'b0;
  endtask

  task automatic wr_mode(input logic v);
    @(negedge clk); addr_mode_we_i = 1'b1; addr_mode_wdata_i = v;
    @(negedge clk); addr_mode_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", rx_irq_o, 0);
    check("R1 data", rx_data_o, 0);
    check("R1 bit9", rx_bit9_o, 0);
    check("R1 mode", addr_mode_o, 0);
  endtask

  task automatic t_byte8();
    nine_bit_i = 1'b0;
    send(9'h0A5, 8, 1'b1, -1);
    check("R2 data", rx_data_o, 8'hA5);
    check("R2 irq", rx_irq_o, 1);
    check("R3 stop1", rx_bit9_o, 1);
    send(9'h03C, 8, 1'b0, -1);
    check("R7 held data", rx_data_o, 8'hA5);
    check("R7 held bit9", rx_bit9_o, 1);
    check("R7 irq sticky", rx_irq_o, 1);
    clr_irq();
    check("R7 cleared", rx_irq_o, 0);
  endtask

  task automatic t_stop0();
    send(9'h05A, 8, 1'b0, -1);
    check("R3 stop0 bit9", rx_bit9_o, 0);
    check("R3 stop0 data", rx_data_o, 8'h5A);
    clr_irq();
  endtask

  task automatic t_vote();
    send(9'h096, 8, 1'b1, 3);
    check("R6 glitch b3", rx_data_o, 8'h96);
    clr_irq();
    send(9'h0C1, 8, 1'b1, 0);
    check("R6 glitch b0", rx_data_o, 8'hC1);
    clr_irq();
  endtask

  task automatic t_false_start();
    for (int k = 0; k < 6; k++) slot(1'b0);
    for (int k = 0; k < 24; k++) slot(1'b1);
    repeat (6) @(negedge clk);
    check("R5 no frame", rx_irq_o, 0);
    send(9'h011, 8, 1'b1, -1);
    check("R5 next frame", rx_data_o, 8'h11);
    clr_irq();
  endtask

  task automatic t_nine();
    nine_bit_i = 1'b1;
    send(9'h0C3, 9, 1'b1, -1);
    check("R4 data", rx_data_o, 8'hC3);
    check("R4 bit9 0", rx_bit9_o, 0);
    clr_irq();
    send(9'h124, 9, 1'b1, -1);
    check("R4 bit9 1", rx_bit9_o, 1);
    check("R4 data2", rx_data_o, 8'h24);
    clr_irq();
  endtask

  task automatic t_mode_write();
    wr_mode(1'b1);
    check("R13 set", addr_mode_o, 1);
    wr_mode(1'b0);
    check("R13 clear", addr_mode_o, 0);
  endtask

  task automatic t_gate();
    wr_mode(1'b1);
    send(9'h077, 9, 1'b1, -1);
    check("R8 no irq", rx_irq_o, 0);
    check("R8 data kept", rx_data_o, 8'h24);
    check("R8 mode kept", addr_mode_o, 1);
  endtask

  task automatic t_addr_noauto();
    auto_match_en_i = 1'b0;
    send(9'h142, 9, 1'b1, -1);
    check("R9 irq match", rx_irq_o, 1);
    check("R9 data", rx_data_o, 8'h42);
    check("R11 mode kept no auto", addr_mode_o, 1);
    clr_irq();
  endtask

  task automatic t_nomatch();
    auto_match_en_i = 1'b1;
    send(9'h155, 9, 1'b1, -1);
    check("R9 irq nomatch", rx_irq_o, 1);
    check("R9 data nomatch", rx_data_o, 8'h55);
    check("R11 mode kept nomatch", addr_mode_o, 1);
    clr_irq();
    send(9'h066, 9, 1'b1, -1);
    check("R8 unselected no irq", rx_irq_o, 0);
    check("R8 unselected data", rx_data_o, 8'h55);
  endtask

  task automatic t_match();
    send(9'h142, 9, 1'b1, -1);
    check("R10 irq", rx_irq_o, 1);
    check("R10 mode cleared", addr_mode_o, 0);
    clr_irq();
    send(9'h066, 9, 1'b1, -1);
    check("R10 data after match", rx_data_o, 8'h66);
    check("R10 irq after match", rx_irq_o, 1);
    check("R10 bit9", rx_bit9_o, 0);
    clr_irq();
  endtask

  task automatic t_8bit_ignore();
    nine_bit_i = 1'b0;
    wr_mode(1'b1);
    send(9'h081, 8, 1'b1, -1);
    check("R12 irq", rx_irq_o, 1);
    check("R12 data", rx_data_o, 8'h81);
    check("R12 mode kept", addr_mode_o, 1);
    clr_irq();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte8();
    t_stop0();
    t_vote();
    t_false_start();
    t_nine();
    t_mode_write();
    t_gate();
    t_addr_noauto();
    t_nomatch();
    t_match();
    t_8bit_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule